// File: doc/BRIEF.md
# Inter-Processor Flag Mailbox

This block lets one processor tell another that a message is waiting. It holds a bank of 32 one-bit flags, and each processor reaches the bank through its own small register port. Both ports run on one clock. The sending processor raises flags by writing ones to its set register. It can read the whole bank back through its flag register, and it can also drop flags through its clear register. The receiving processor sees the same bank as its status register and drops flags by writing ones to its acknowledge register.

Register bit n stands for flag number n+1, so bit 9 is flag 10. The four lowest flags each drive a level interrupt line toward the receiver. The receiver can poll the status register for any flag. A second instance of the block serves the opposite direction.

Top module: `ipc_flag_mailbox`

## Requirements
- R1: A synchronous active-low reset clears every flag. After reset, both readback registers return zero and all interrupt lines are low.
- R2: A sender write to offset 0x0 (set) raises flag bit n for every data bit n that is one. Bits written as zero leave their flags unchanged. The new value is readable in the cycle after the write strobe.
- R3: The sender's flag register (sender offset 0x8) and the receiver's status register (receiver offset 0x0) always return the same stored 32-bit value.
- R4: A receiver write to offset 0x4 (acknowledge) clears flag bit n for every data bit n that is one. All other flags stay as they were.
- R5: A sender write to offset 0x4 (clear) clears flags the same way the acknowledge write does.
- R6: When a set and a clear hit the same bit in the same cycle, the set wins and the flag ends up high.
- R7: Interrupt output k (k = 0..3) is high exactly while flag bit k is set. Flags at bit 4 and above drive no interrupt.
- R8: Reads of the set and clear offsets on the sender port, and of the acknowledge offset on the receiver port, return zero. Writes to the flag register, to the status register or to any unmapped offset leave the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports |
| rstN | input | 1 | Synchronous reset, active low |
| sndAddr | input | 4 | Sender port register offset |
| sndWe | input | 1 | Sender write strobe |
| sndWdata | input | 32 | Sender write data |
| sndRdata | output | 32 | Sender read data, selected by sndAddr |
| rcvAddr | input | 4 | Receiver port register offset |
| rcvWe | input | 1 | Receiver write strobe |
| rcvWdata | input | 32 | Receiver write data |
| rcvRdata | output | 32 | Receiver read data, selected by rcvAddr |
| irqOut | output | 4 | Level interrupts toward the receiver, one per flag 1..4 |

## Verification
The hardest case to reach is a set and an acknowledge hitting the same bit in the same cycle. The two writes come from separate ports, so a bench that drives one port at a time never produces the collision. The stimulus drives both write strobes in a single cycle, with overlapping masks, both in a directed case and throughout a pseudo-random phase, and a bench model applies clear-then-set to predict the result. A per-bit sweep walks a single one through all 32 positions, alternating between the two clear paths, to reach each bit and each interrupt line on its own.

// File: rtl/ipc_flag_pkg.sv
package ipc_flag_pkg;

  // Register offsets on the sender port
  localparam int unsigned SND_SET_OFF = 0;
  localparam int unsigned SND_CLR_OFF = 4;
  localparam int unsigned SND_FLG_OFF = 8;

  // Register offsets on the receiver port
  localparam int unsigned RCV_STS_OFF = 0;
  localparam int unsigned RCV_ACK_OFF = 4;

  // Strobes from control to datapath
  typedef struct packed {
    logic setEn;     // sender set write this cycle
    logic sndClrEn;  // sender clear write this cycle
    logic rcvAckEn;  // receiver acknowledge write this cycle
    logic sndRdFlg;  // sender read selects the flag bank
    logic rcvRdSts;  // receiver read selects the flag bank
  } flagCtrl_t;

endpackage

// File: rtl/ipc_flag_ctrl.sv
module ipc_flag_ctrl
  import ipc_flag_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] sndAddr,
  input  logic              sndWe,
  input  logic [ADDR_W-1:0] rcvAddr,
  input  logic              rcvWe,
  output flagCtrl_t         ctrl
);

  localparam logic [ADDR_W-1:0] SetAddr = ADDR_W'(SND_SET_OFF);
  localparam logic [ADDR_W-1:0] ClrAddr = ADDR_W'(SND_CLR_OFF);
  localparam logic [ADDR_W-1:0] FlgAddr = ADDR_W'(SND_FLG_OFF);
  localparam logic [ADDR_W-1:0] StsAddr = ADDR_W'(RCV_STS_OFF);
  localparam logic [ADDR_W-1:0] AckAddr = ADDR_W'(RCV_ACK_OFF);

  logic sndHitSet;
  logic sndHitClr;
  logic rcvHitAck;

  always_comb begin
    sndHitSet = (sndAddr == SetAddr);
    sndHitClr = (sndAddr == ClrAddr);
    rcvHitAck = (rcvAddr == AckAddr);

    ctrl          = '0;
    ctrl.setEn    = sndWe & sndHitSet;
    ctrl.sndClrEn = sndWe & sndHitClr;
    ctrl.rcvAckEn = rcvWe & rcvHitAck;
    // Set, clear and acknowledge are write-only; only the bank reads back
    ctrl.sndRdFlg = (sndAddr == FlgAddr);
    ctrl.rcvRdSts = (rcvAddr == StsAddr);
  end

endmodule

// File: rtl/ipc_flag_dp.sv
module ipc_flag_dp
  import ipc_flag_pkg::*;
#(
  parameter int unsigned NUM_FLAGS = 32,
  parameter int unsigned NUM_IRQ   = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  flagCtrl_t            ctrl,
  input  logic [NUM_FLAGS-1:0] sndWdata,
  input  logic [NUM_FLAGS-1:0] rcvWdata,
  output logic [NUM_FLAGS-1:0] flagQ,
  output logic [NUM_FLAGS-1:0] sndRdata,
  output logic [NUM_FLAGS-1:0] rcvRdata,
  output logic [NUM_IRQ-1:0]   irqOut
);

  logic [NUM_FLAGS-1:0] setMask;
  logic [NUM_FLAGS-1:0] clrMask;

  always_comb begin
    setMask = ctrl.setEn ? sndWdata : '0;
    clrMask = (ctrl.sndClrEn ? sndWdata : '0) | (ctrl.rcvAckEn ? rcvWdata : '0);
  end

  // One storage cell per flag; set has priority over clear
  for (genvar b = 0; b < NUM_FLAGS; b++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN)            flagQ[b] <= 1'b0;
      else if (setMask[b])  flagQ[b] <= 1'b1;
      else if (clrMask[b])  flagQ[b] <= 1'b0;
    end
  end

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_irq
    assign irqOut[k] = flagQ[k];
  end

  always_comb begin
    sndRdata = ctrl.sndRdFlg ? flagQ : '0;
    rcvRdata = ctrl.rcvRdSts ? flagQ : '0;
  end

endmodule

// File: rtl/ipc_flag_mailbox.sv
module ipc_flag_mailbox
  import ipc_flag_pkg::*;
#(
  parameter int unsigned NUM_FLAGS = 32,
  parameter int unsigned NUM_IRQ   = 4,
  parameter int unsigned ADDR_W    = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    sndAddr,
  input  logic                 sndWe,
  input  logic [NUM_FLAGS-1:0] sndWdata,
  output logic [NUM_FLAGS-1:0] sndRdata,
  input  logic [ADDR_W-1:0]    rcvAddr,
  input  logic                 rcvWe,
  input  logic [NUM_FLAGS-1:0] rcvWdata,
  output logic [NUM_FLAGS-1:0] rcvRdata,
  output logic [NUM_IRQ-1:0]   irqOut
);

  flagCtrl_t            ctrl;
  logic [NUM_FLAGS-1:0] flagQ;

  ipc_flag_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .sndAddr (sndAddr),
    .sndWe   (sndWe),
    .rcvAddr (rcvAddr),
    .rcvWe   (rcvWe),
    .ctrl    (ctrl)
  );

  ipc_flag_dp #(.NUM_FLAGS(NUM_FLAGS), .NUM_IRQ(NUM_IRQ)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .sndWdata (sndWdata),
    .rcvWdata (rcvWdata),
    .flagQ    (flagQ),
    .sndRdata (sndRdata),
    .rcvRdata (rcvRdata),
    .irqOut   (irqOut)
  );

endmodule

// File: rtl/ipc_flag_chk.sv
module ipc_flag_chk
  import ipc_flag_pkg::*;
#(
  parameter int unsigned NUM_FLAGS = 32,
  parameter int unsigned NUM_IRQ   = 4,
  parameter int unsigned ADDR_W    = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [ADDR_W-1:0]    sndAddr,
  input logic                 sndWe,
  input logic [NUM_FLAGS-1:0] sndWdata,
  input logic [NUM_FLAGS-1:0] sndRdata,
  input logic [ADDR_W-1:0]    rcvAddr,
  input logic                 rcvWe,
  input logic [NUM_FLAGS-1:0] rcvWdata,
  input logic [NUM_FLAGS-1:0] rcvRdata,
  input logic [NUM_IRQ-1:0]   irqOut,
  input logic [NUM_FLAGS-1:0] flagQ
);

  localparam logic [ADDR_W-1:0] SetA = ADDR_W'(SND_SET_OFF);
  localparam logic [ADDR_W-1:0] ClrA = ADDR_W'(SND_CLR_OFF);
  localparam logic [ADDR_W-1:0] FlgA = ADDR_W'(SND_FLG_OFF);
  localparam logic [ADDR_W-1:0] StsA = ADDR_W'(RCV_STS_OFF);
  localparam logic [ADDR_W-1:0] AckA = ADDR_W'(RCV_ACK_OFF);

  logic setW, sndClrW, ackW, anyClr;
  logic rstSeen;

  assign setW    = sndWe && (sndAddr == SetA);
  assign sndClrW = sndWe && (sndAddr == ClrA);
  assign ackW    = rcvWe && (rcvAddr == AckA);
  assign anyClr  = sndClrW || ackW;

  always_ff @(posedge clk) begin
    rstSeen <= !rstN;
    if (rstSeen) begin
      assert_reset_clear_R1: assert (flagQ == '0 && irqOut == '0 && sndRdata == '0 && rcvRdata == '0);
    end
    if (rstN) begin
      if (sndAddr == FlgA && rcvAddr == StsA) begin
        assert_same_bank_R3: assert (sndRdata == rcvRdata);
      end
      if (sndAddr == SetA || sndAddr == ClrA) begin
        assert_snd_wo_zero_R8: assert (sndRdata == '0);
      end
      if (rcvAddr == AckA) begin
        assert_rcv_wo_zero_R8: assert (rcvRdata == '0);
      end
    end
  end

  property pSetRaises;
    @(posedge clk) disable iff (!rstN)
      setW |=> ((flagQ & $past(sndWdata)) == $past(sndWdata));
  endproperty
  assert_set_raises_R2: assert property (pSetRaises);

  property pAckClears;
    @(posedge clk) disable iff (!rstN)
      (ackW && !setW) |=> ((flagQ & $past(rcvWdata)) == '0);
  endproperty
  assert_ack_clears_R4: assert property (pAckClears);

  property pClrClears;
    @(posedge clk) disable iff (!rstN)
      sndClrW |=> ((flagQ & $past(sndWdata)) == '0);
  endproperty
  assert_clr_clears_R5: assert property (pClrClears);

  property pSetWins;
    @(posedge clk) disable iff (!rstN)
      (setW && ackW) |=> ((flagQ & $past(sndWdata)) == $past(sndWdata));
  endproperty
  assert_set_wins_R6: assert property (pSetWins);

  property pNoWriteStable;
    @(posedge clk) disable iff (!rstN)
      (!setW && !anyClr) |=> $stable(flagQ);
  endproperty
  assert_ignored_write_R8: assert property (pNoWriteStable);

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_irqChk
    property pIrqRise;
      @(posedge clk) disable iff (!rstN)
        (setW && sndWdata[k]) |=> irqOut[k];
    endproperty
    assert_irq_rise_R7: assert property (pIrqRise);

    property pIrqFall;
      @(posedge clk) disable iff (!rstN)
        (ackW && rcvWdata[k] && !(setW && sndWdata[k])) |=> !irqOut[k];
    endproperty
    assert_irq_fall_R7: assert property (pIrqFall);
  end

endmodule

bind ipc_flag_mailbox ipc_flag_chk #(
  .NUM_FLAGS (NUM_FLAGS),
  .NUM_IRQ   (NUM_IRQ),
  .ADDR_W    (ADDR_W)
) u_chk (.*);

// File: tb/ipc_flag_mailbox_tb.sv
`timescale 1ns/1ps
module ipc_flag_mailbox_tb;

  localparam int unsigned NF = 32;
  localparam int unsigned NI = 4;
  localparam int unsigned AW = 4;

  logic          clk = 1'b0;
  logic          rstN;
  logic [AW-1:0] sndAddr, rcvAddr;
  logic          sndWe, rcvWe;
  logic [NF-1:0] sndWdata, rcvWdata, sndRdata, rcvRdata;
  logic [NI-1:0] irqOut;

  logic [NF-1:0] model;
  logic [31:0]   lfsr;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ipc_flag_mailbox #(.NUM_FLAGS(NF), .NUM_IRQ(NI), .ADDR_W(AW)) u_dut (
    .clk(clk), .rstN(rstN),
    .sndAddr(sndAddr), .sndWe(sndWe), .sndWdata(sndWdata), .sndRdata(sndRdata),
    .rcvAddr(rcvAddr), .rcvWe(rcvWe), .rcvWdata(rcvWdata), .rcvRdata(rcvRdata),
    .irqOut(irqOut)
  );

  task automatic check(input logic ok, input string req, input logic [NF-1:0] act, input logic [NF-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock with optional writes on both ports; model: clear first, then set
  task automatic cyc(input logic sw, input logic [AW-1:0] sa, input logic [NF-1:0] sd,
                     input logic rw, input logic [AW-1:0] ra, input logic [NF-1:0] rd);
    logic [NF-1:0] setM, clrM;
    @(negedge clk);
    sndWe = sw; sndAddr = sa; sndWdata = sd;
    rcvWe = rw; rcvAddr = ra; rcvWdata = rd;
    @(posedge clk);
    @(negedge clk);
    sndWe = 1'b0; rcvWe = 1'b0;
    setM = (sw && sa == 4'h0) ? sd : '0;
    clrM = ((sw && sa == 4'h4) ? sd : '0) | ((rw && ra == 4'h4) ? rd : '0);
    if (rstN) model = (model & ~clrM) | setM;
  endtask

  task automatic checkBank(input string req);
    sndAddr = 4'h8; rcvAddr = 4'h0;
    #1;
    check(sndRdata == model, req, sndRdata, model);
    check(rcvRdata == model, {req, "/R3"}, rcvRdata, model);
    check(irqOut == model[NI-1:0], {req, "/R7"}, NF'(irqOut), NF'(model[NI-1:0]));
  endtask

  task automatic checkWoZero();
    sndAddr = 4'h0; rcvAddr = 4'h4; #1;
    check(sndRdata == '0, "R8 set reads zero", sndRdata, '0);
    check(rcvRdata == '0, "R8 ack reads zero", rcvRdata, '0);
    sndAddr = 4'h4; #1;
    check(sndRdata == '0, "R8 clr reads zero", sndRdata, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; sndWe = 0; rcvWe = 0; sndAddr = '0; rcvAddr = '0;
    sndWdata = '0; rcvWdata = '0; model = '0; lfsr = 32'h1ACE_B00C;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    checkBank("R1 after reset");

    // Walking-one sweep: set, check, clear through alternating paths
    for (int n = 0; n < NF; n++) begin
      cyc(1, 4'h0, NF'(1) << n, 0, 4'h0, '0);
      checkBank("R2 single-bit set");
      check(model == (NF'(1) << n), "R2 model", model, NF'(1) << n);
      if (n < 3) checkWoZero();
      if (n % 2 == 0) begin
        cyc(0, 4'h0, '0, 1, 4'h4, NF'(1) << n);
        checkBank("R4 ack clear");
      end else begin
        cyc(1, 4'h4, NF'(1) << n, 0, 4'h0, '0);
        checkBank("R5 sender clear");
      end
      check(sndRdata == '0, "R4/R5 bank empty", sndRdata, '0);
    end

    // Zero bits have no effect; partial clears
    cyc(1, 4'h0, 32'hA5A5_0F0F, 0, 4'h0, '0);
    cyc(1, 4'h0, 32'h0000_0000, 0, 4'h0, '0);
    checkBank("R2 zero write no effect");
    cyc(0, 4'h0, '0, 1, 4'h4, 32'h0000_000F);
    checkBank("R4 partial ack");

    // Writes to read-only and unmapped offsets are ignored
    cyc(1, 4'h8, 32'hFFFF_FFFF, 1, 4'h0, 32'hFFFF_FFFF);
    checkBank("R8 write to flag/status ignored");
    cyc(1, 4'hC, 32'hFFFF_FFFF, 1, 4'h8, 32'hFFFF_FFFF);
    checkBank("R8 unmapped write ignored");
    check(model == 32'hA5A5_0F00, "R8 model", model, 32'hA5A5_0F00);

    // Collision: set and acknowledge on the same bits in one cycle
    cyc(1, 4'h0, 32'h0000_00F3, 1, 4'h4, 32'hFFFF_FFFF);
    checkBank("R6 set beats ack");
    check(model == 32'h0000_00F3, "R6 model", model, 32'h0000_00F3);

    // Pseudo-random traffic on both ports
    for (int i = 0; i < 400; i++) begin
      logic [NF-1:0] a, b;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      a = lfsr;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      b = lfsr;
      cyc(a[0], {a[3:2], 2'b00}, a & {b[31:16], b[15:0]}, b[1], {1'b0, b[2], 2'b00}, b ^ a);
      checkBank("R6 random mix");
    end

    // Reset while flags are set
    cyc(1, 4'h0, 32'hFFFF_FFFF, 0, 4'h0, '0);
    @(negedge clk); rstN = 1'b0;
    @(posedge clk); @(negedge clk); rstN = 1'b1; model = '0;
    checkBank("R1 mid-run reset");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule